// File: doc/BRIEF.md
# Port-Addressed Clause 45 Management Controller

This block is a management-bus master that lets software reach Ethernet PHYs through switch port numbers instead of bus and PHY addresses. Two lookup tables, held in registers, tie each of up to 32 ports to one of four physical management buses and to a 5-bit PHY address on that bus. Software loads the tables once at bring-up. After that it names a port, a device address and a register number, and then starts a command.

A command sequencer turns each access into two Clause 45 frames. The first is an address frame and the second a read or write frame. Both are sent on the bus that belongs to the port. Each bus has its own serialiser and its own clock and data pins. The data pin is split into output, output-enable and input. The sequencer shows busy while it works. It returns read data into the data register. It sets a fail flag when the PHY does not pull the turnaround low, and it still finishes normally in that case.

Register access is a plain single-cycle write strobe with a combinational read-back, decoded on a 12-bit byte offset.

Top module: `portmdio_ctrl`

## Requirements
- R1: After reset every register reads back zero. Every clock output is low and every data-output enable is low.
- R2: The PHY address table holds 5-bit fields, six ports to a 32-bit word, in words at offset 0x180 + 4*(i/6). Port i sits at bit (i mod 6)*5. Each word reads back as written.
- R3: The bus-select table holds 2-bit fields, sixteen ports to a word, in words at offset 0x008 + 4*(i/16). Port i sits at bit (i mod 16)*2. Each word reads back as written.
- R4: Bit 16+n of the word at offset 0x000 enables Clause 45 on bus n. A started command whose bus is not enabled, or whose frame-type bit is clear, finishes at once: fail is set, busy is clear, and no bus clock toggles.
- R5: The command word at offset 0x174 has these bits. Bit 0 starts a command and reads 1 while the command runs. Bit 1 selects Clause 45. Bit 2 is 1 for write and 0 for read. Bit 25 reads 1 after a failed access. A successful access clears bit 25.
- R6: A read takes its port from bits 20:16 of the data word at 0x178. It takes the device address from bits 20:16 and the register number from bits 15:0 of the word at 0x17C. When the read completes, the read data is placed in bits 15:0 of 0x178.
- R7: A write takes its port from the lowest set bit of the bitmap at 0x170 and its data from bits 31:16 of 0x178.
- R8: Each access sends two 64-bit frames, MSB first: 32 ones, start 00, an op code, the PHY address, the device address, turnaround 10, then 16 bits. The first frame uses op 00 and carries the register number. The second uses op 01 with the write data, or op 11 for a read.
- R9: The bus clock period is 2*MDC_HALF system clocks. Data changes after the falling edge and is sampled on the rising edge. During a read frame the output enable is low for the turnaround and the data bits.
- R10: If the PHY leaves the second turnaround bit of a read high, the access completes with fail set and the read data reads 0xFFFF.
- R11: A start written while busy is ignored. It has no effect on the running command and does not change the command bits that read back.
- R12: Only the bus mapped to the addressed port toggles its clock during a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mdc | output | NUM_BUSES | Per-bus management clock |
| mdio_o | output | NUM_BUSES | Per-bus data out |
| mdio_oe | output | NUM_BUSES | Per-bus data output enable |
| mdio_i | input | NUM_BUSES | Per-bus data in |

## Verification
The bench first maps four ports onto four different buses with different PHY addresses. It then runs a read, a write, a read from an absent PHY and a follow-up good read. Because each port is on its own bus, a wrong table field or a wrong bit position sends frames to the wrong bus or puts the wrong address into a frame. The write uses a bitmap with two bits set, so the bench can tell lowest-bit selection from any other choice. The absent-PHY read separates the turnaround fail path from normal completion. A start issued while a command is busy, and a start on a bus without Clause 45 enabled, each show that a command with no effect leaves the frame counts and the read-back bits unchanged.

// File: rtl/portmdio_pkg.sv
package portmdio_pkg;

    localparam logic [11:0] OFS_GLOBAL = 12'h000;
    localparam logic [11:0] OFS_BUSSEL = 12'h008;
    localparam logic [11:0] OFS_WRMAP  = 12'h170;
    localparam logic [11:0] OFS_CMD    = 12'h174;
    localparam logic [11:0] OFS_DATA   = 12'h178;
    localparam logic [11:0] OFS_DEVREG = 12'h17C;
    localparam logic [11:0] OFS_PHYTAB = 12'h180;

    localparam int MAX_BUSES   = 4;
    localparam int FRAME_BITS  = 64;
    localparam int PHY_FIELD   = 5;
    localparam int SEL_FIELD   = 2;

    localparam logic [1:0] OP_ADDR  = 2'b00;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b11;

    typedef struct packed {
        logic [SEL_FIELD-1:0] bus;
        logic [PHY_FIELD-1:0] phy;
    } target_t;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_ADDR = 2'd1,
        SQ_ACC  = 2'd2
    } seq_state_t;

    function automatic logic [FRAME_BITS-1:0] build_frame(
        input logic [1:0]  op,
        input logic [4:0]  phy,
        input logic [4:0]  dev,
        input logic [15:0] payload
    );
        return {32'hFFFF_FFFF, 2'b00, op, phy, dev, 2'b10, payload};
    endfunction

endpackage

// File: rtl/portmdio_map.sv
module portmdio_map
    import portmdio_pkg::*;
#(
    parameter int NUM_PORTS = 32
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [11:0]                  addr,
    input  logic [31:0]                  wdata,
    input  logic [$clog2(NUM_PORTS)-1:0] lookup_port,
    output target_t                      lookup_tgt,
    output logic                         rd_hit,
    output logic [31:0]                  rd_word
);
    localparam int PORT_W     = $clog2(NUM_PORTS);
    localparam int ADDR_WORDS = (NUM_PORTS + 5) / 6;
    localparam int SEL_WORDS  = (NUM_PORTS + 15) / 16;
    localparam int AW_IW      = (ADDR_WORDS > 1) ? $clog2(ADDR_WORDS) : 1;
    localparam int SW_IW      = (SEL_WORDS > 1) ? $clog2(SEL_WORDS) : 1;

    logic [31:0] phy_tab [ADDR_WORDS];
    logic [31:0] sel_tab [SEL_WORDS];

    always_ff @(posedge clk) begin
        for (int w = 0; w < ADDR_WORDS; w++) begin
            if (rst)
                phy_tab[w] <= '0;
            else if (wr_en && addr == 12'(OFS_PHYTAB + 4 * w))
                phy_tab[w] <= wdata;
        end
        for (int w = 0; w < SEL_WORDS; w++) begin
            if (rst)
                sel_tab[w] <= '0;
            else if (wr_en && addr == 12'(OFS_BUSSEL + 4 * w))
                sel_tab[w] <= wdata;
        end
    end

    // Translate the port into a bus number and a PHY address
    logic [AW_IW-1:0] aw_idx;
    logic [SW_IW-1:0] sw_idx;
    logic [4:0]       phy_pos;
    logic [4:0]       sel_pos;

    always_comb begin
        aw_idx  = AW_IW'(lookup_port / PORT_W'(6));
        phy_pos = 5'((lookup_port % PORT_W'(6)) * PORT_W'(5));
        sw_idx  = SW_IW'(lookup_port >> 4);
        sel_pos = {lookup_port[3:0], 1'b0};
        lookup_tgt.phy = phy_tab[aw_idx][phy_pos +: PHY_FIELD];
        lookup_tgt.bus = sel_tab[sw_idx][sel_pos +: SEL_FIELD];
    end

    always_comb begin
        rd_hit  = 1'b0;
        rd_word = '0;
        for (int w = 0; w < ADDR_WORDS; w++) begin
            if (addr == 12'(OFS_PHYTAB + 4 * w)) begin
                rd_hit  = 1'b1;
                rd_word = phy_tab[w];
            end
        end
        for (int w = 0; w < SEL_WORDS; w++) begin
            if (addr == 12'(OFS_BUSSEL + 4 * w)) begin
                rd_hit  = 1'b1;
                rd_word = sel_tab[w];
            end
        end
    end

endmodule

// File: rtl/portmdio_serdes.sv
module portmdio_serdes
    import portmdio_pkg::*;
#(
    parameter int MDC_HALF = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [FRAME_BITS-1:0] frame,
    input  logic                  is_read,
    input  logic                  mdio_i,
    output logic                  mdc,
    output logic                  mdio_o,
    output logic                  mdio_oe,
    output logic                  done,
    output logic                  ta_ok,
    output logic [15:0]           rdata
);
    localparam int DW = (MDC_HALF > 1) ? $clog2(MDC_HALF) : 1;
    localparam logic [DW-1:0] DIV_LAST = DW'(MDC_HALF - 1);

    logic                  active;
    logic                  rd_q;
    logic [DW-1:0]         div_cnt;
    logic [5:0]            idx;
    logic [FRAME_BITS-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            rd_q    <= 1'b0;
            div_cnt <= '0;
            idx     <= '0;
            sh      <= '0;
            mdc     <= 1'b0;
            mdio_oe <= 1'b0;
            done    <= 1'b0;
            ta_ok   <= 1'b0;
            rdata   <= '0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (start) begin
                    active  <= 1'b1;
                    rd_q    <= is_read;
                    sh      <= frame;
                    idx     <= '0;
                    div_cnt <= '0;
                    mdc     <= 1'b0;
                    mdio_oe <= 1'b1;
                    ta_ok   <= 1'b0;
                    rdata   <= '0;
                end
            end else if (div_cnt == DIV_LAST) begin
                div_cnt <= '0;
                if (!mdc) begin
                    // rising edge: sample the PHY
                    mdc <= 1'b1;
                    if (rd_q && idx == 6'd47)
                        ta_ok <= !mdio_i;
                    if (rd_q && idx >= 6'd48)
                        rdata <= {rdata[14:0], mdio_i};
                end else begin
                    // falling edge: advance to the next bit
                    mdc <= 1'b0;
                    if (idx == 6'd63) begin
                        active  <= 1'b0;
                        mdio_oe <= 1'b0;
                        done    <= 1'b1;
                    end else begin
                        idx <= idx + 6'd1;
                        sh  <= {sh[FRAME_BITS-2:0], 1'b0};
                        if (rd_q && idx == 6'd45)
                            mdio_oe <= 1'b0;
                    end
                end
            end else begin
                div_cnt <= div_cnt + DW'(1);
            end
        end
    end

    assign mdio_o = sh[FRAME_BITS-1];

    p_turn_released_r9: assert property (@(posedge clk) disable iff (rst)
        (active && rd_q && idx >= 6'd46) |-> !mdio_oe);

    p_mdc_idle_low_r9: assert property (@(posedge clk) disable iff (rst)
        !active |-> !mdc);

endmodule

// File: rtl/portmdio_seq.sv
module portmdio_seq
    import portmdio_pkg::*;
#(
    parameter int NUM_PORTS = 32,
    parameter int NUM_BUSES = 4
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             cmd_we,
    input  logic [2:0]                       cmd_bits,
    input  logic [$clog2(NUM_PORTS)-1:0]     rd_port,
    input  logic [NUM_PORTS-1:0]             wr_map,
    input  logic [15:0]                      wr_data,
    input  logic [4:0]                       dev_in,
    input  logic [15:0]                      reg_in,
    input  logic [MAX_BUSES-1:0]             c45_mask,
    output logic [$clog2(NUM_PORTS)-1:0]     look_port,
    input  target_t                          look_tgt,
    input  logic [MAX_BUSES-1:0]             fr_done,
    input  logic [MAX_BUSES-1:0]             fr_ta_ok,
    input  logic [MAX_BUSES-1:0][15:0]       fr_rdata,
    output logic [MAX_BUSES-1:0]             fr_start,
    output logic [FRAME_BITS-1:0]            fr_word,
    output logic                             fr_read,
    output logic                             busy,
    output logic                             fail,
    output logic                             op_write,
    output logic                             op_c45,
    output logic                             res_we,
    output logic [15:0]                      res_data
);
    localparam int PORT_W = $clog2(NUM_PORTS);

    seq_state_t  state;
    target_t     tgt;
    logic [4:0]  dev_q;
    logic [15:0] reg_q;
    logic [15:0] wdat_q;
    logic        start_q;
    logic        runnable;

    // Write target: lowest set bit of the bitmap
    always_comb begin
        look_port = rd_port;
        if (cmd_bits[2]) begin
            look_port = '0;
            for (int i = NUM_PORTS - 1; i >= 0; i--)
                if (wr_map[i]) look_port = PORT_W'(i);
        end
        runnable = cmd_bits[1] && c45_mask[look_tgt.bus]
                   && (int'(look_tgt.bus) < NUM_BUSES);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SQ_IDLE;
            tgt      <= '0;
            dev_q    <= '0;
            reg_q    <= '0;
            wdat_q   <= '0;
            start_q  <= 1'b0;
            fail     <= 1'b0;
            op_write <= 1'b0;
            op_c45   <= 1'b0;
        end else begin
            start_q <= 1'b0;
            case (state)
                SQ_IDLE: if (cmd_we) begin
                    op_write <= cmd_bits[2];
                    op_c45   <= cmd_bits[1];
                    if (cmd_bits[0]) begin
                        tgt    <= look_tgt;
                        dev_q  <= dev_in;
                        reg_q  <= reg_in;
                        wdat_q <= wr_data;
                        if (runnable) begin
                            fail    <= 1'b0;
                            state   <= SQ_ADDR;
                            start_q <= 1'b1;
                        end else begin
                            fail <= 1'b1;
                        end
                    end
                end
                SQ_ADDR: if (fr_done[tgt.bus]) begin
                    state   <= SQ_ACC;
                    start_q <= 1'b1;
                end
                SQ_ACC: if (fr_done[tgt.bus]) begin
                    state <= SQ_IDLE;
                    fail  <= !op_write && !fr_ta_ok[tgt.bus];
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    always_comb begin
        busy     = (state != SQ_IDLE);
        fr_start = start_q ? (MAX_BUSES'(1) << tgt.bus) : '0;
        fr_read  = (state == SQ_ACC) && !op_write;
        if (state == SQ_ADDR)
            fr_word = build_frame(OP_ADDR, tgt.phy, dev_q, reg_q);
        else
            fr_word = build_frame(op_write ? OP_WRITE : OP_READ, tgt.phy, dev_q,
                                  op_write ? wdat_q : 16'hFFFF);
        res_we   = (state == SQ_ACC) && fr_done[tgt.bus] && !op_write;
        res_data = fr_ta_ok[tgt.bus] ? fr_rdata[tgt.bus] : 16'hFFFF;
    end

    p_busy_start_ignored_r11: assert property (@(posedge clk) disable iff (rst)
        (busy && cmd_we) |=> ($stable(tgt) && $stable(op_write) && $stable(dev_q)));

    p_done_frees_r5: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_ACC && fr_done[tgt.bus]) |=> !busy);

endmodule

// File: rtl/portmdio_ctrl.sv
module portmdio_ctrl
    import portmdio_pkg::*;
#(
    parameter int NUM_PORTS = 32,
    parameter int NUM_BUSES = 4,
    parameter int MDC_HALF  = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr,
    input  logic [11:0]          reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    output logic [NUM_BUSES-1:0] mdc,
    output logic [NUM_BUSES-1:0] mdio_o,
    output logic [NUM_BUSES-1:0] mdio_oe,
    input  logic [NUM_BUSES-1:0] mdio_i
);
    localparam int PORT_W = $clog2(NUM_PORTS);

    logic [NUM_BUSES-1:0] c45_q;
    logic [NUM_PORTS-1:0] wrmap_q;
    logic [31:0]          data_q;
    logic [4:0]           dev_q;
    logic [15:0]          regn_q;

    logic [PORT_W-1:0]               look_port;
    target_t                         look_tgt;
    logic                            map_hit;
    logic [31:0]                     map_word;
    logic [MAX_BUSES-1:0]            fr_done, fr_ta_ok, fr_start;
    logic [MAX_BUSES-1:0][15:0]      fr_rdata;
    logic [FRAME_BITS-1:0]           fr_word;
    logic                            fr_read;
    logic                            busy, fail, op_write, op_c45, res_we;
    logic [15:0]                     res_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            c45_q   <= '0;
            wrmap_q <= '0;
            data_q  <= '0;
            dev_q   <= '0;
            regn_q  <= '0;
        end else begin
            if (reg_wr) begin
                case (reg_addr)
                    OFS_GLOBAL: c45_q   <= reg_wdata[16 +: NUM_BUSES];
                    OFS_WRMAP:  wrmap_q <= reg_wdata[NUM_PORTS-1:0];
                    OFS_DATA:   data_q  <= reg_wdata;
                    OFS_DEVREG: begin
                        dev_q  <= reg_wdata[20:16];
                        regn_q <= reg_wdata[15:0];
                    end
                    default: ;
                endcase
            end
            if (res_we)
                data_q[15:0] <= res_data;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (map_hit) begin
            reg_rdata = map_word;
        end else begin
            case (reg_addr)
                OFS_GLOBAL: reg_rdata[16 +: NUM_BUSES] = c45_q;
                OFS_WRMAP:  reg_rdata[NUM_PORTS-1:0]   = wrmap_q;
                OFS_CMD:    reg_rdata = {6'b0, fail, 22'b0, op_write, op_c45, busy};
                OFS_DATA:   reg_rdata = data_q;
                OFS_DEVREG: reg_rdata = {11'b0, dev_q, regn_q};
                default:    reg_rdata = '0;
            endcase
        end
    end

    portmdio_map #(.NUM_PORTS(NUM_PORTS)) u_map (
        .clk(clk), .rst(rst), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .lookup_port(look_port), .lookup_tgt(look_tgt),
        .rd_hit(map_hit), .rd_word(map_word)
    );

    portmdio_seq #(.NUM_PORTS(NUM_PORTS), .NUM_BUSES(NUM_BUSES)) u_seq (
        .clk(clk), .rst(rst),
        .cmd_we(reg_wr && reg_addr == OFS_CMD), .cmd_bits(reg_wdata[2:0]),
        .rd_port(data_q[16 +: PORT_W]), .wr_map(wrmap_q), .wr_data(data_q[31:16]),
        .dev_in(dev_q), .reg_in(regn_q), .c45_mask(MAX_BUSES'(c45_q)),
        .look_port(look_port), .look_tgt(look_tgt),
        .fr_done(fr_done), .fr_ta_ok(fr_ta_ok), .fr_rdata(fr_rdata),
        .fr_start(fr_start), .fr_word(fr_word), .fr_read(fr_read),
        .busy(busy), .fail(fail), .op_write(op_write), .op_c45(op_c45),
        .res_we(res_we), .res_data(res_data)
    );

    for (genvar b = 0; b < MAX_BUSES; b++) begin : g_bus
        if (b < NUM_BUSES) begin : g_on
            portmdio_serdes #(.MDC_HALF(MDC_HALF)) u_ser (
                .clk(clk), .rst(rst), .start(fr_start[b]), .frame(fr_word),
                .is_read(fr_read), .mdio_i(mdio_i[b]),
                .mdc(mdc[b]), .mdio_o(mdio_o[b]), .mdio_oe(mdio_oe[b]),
                .done(fr_done[b]), .ta_ok(fr_ta_ok[b]), .rdata(fr_rdata[b])
            );
        end else begin : g_off
            assign fr_done[b]  = 1'b0;
            assign fr_ta_ok[b] = 1'b0;
            assign fr_rdata[b] = '0;
        end
    end

    p_single_mdc_r12: assert property (@(posedge clk) disable iff (rst)
        $onehot0(mdc));

    p_fail_reads_ones_r10: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && fail && !op_write) |-> data_q[15:0] == 16'hFFFF);

endmodule

// File: tb/portmdio_ctrl_test.sv
`timescale 1ns/1ps
module portmdio_ctrl_test;
    localparam int NB = 4;
    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [NB-1:0] mdc, mdio_o, mdio_oe;
    logic [NB-1:0] phy_in = '1;

    int total = 0;
    int fails = 0;
    int cyc = 0;

    logic [63:0] cap [NB];
    logic [63:0] last_f [NB];
    logic [63:0] prev_f [NB];
    int          cnt [NB];
    int          nfr [NB];
    int          gap [NB];
    int          last_rise [NB];
    logic        rdop [NB];
    logic        phy_present [NB];
    logic [15:0] phy_resp [NB];
    logic [NB-1:0] mdc_prev = '0;

    portmdio_ctrl #(.NUM_PORTS(32), .NUM_BUSES(NB), .MDC_HALF(HALF)) uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(phy_in)
    );

    always #2.5 clk = ~clk;

    initial begin
        for (int b = 0; b < NB; b++) begin
            cap[b] = '0; last_f[b] = '0; prev_f[b] = '0;
            cnt[b] = 0; nfr[b] = 0; gap[b] = 0; last_rise[b] = 0;
            rdop[b] = 1'b0; phy_present[b] = 1'b0; phy_resp[b] = '0;
        end
    end

    // PHY models, one per bus, evaluated away from the active edge
    always @(negedge clk) begin
        cyc++;
        for (int b = 0; b < NB; b++) begin
            if (mdc[b] && !mdc_prev[b]) begin
                if (cnt[b] != 0) gap[b] = cyc - last_rise[b];
                last_rise[b] = cyc;
                cap[b] = {cap[b][62:0], mdio_oe[b] ? mdio_o[b] : 1'b1};
                cnt[b]++;
                if (cnt[b] == 36) rdop[b] = (cap[b][1:0] == 2'b11);
                if (cnt[b] == 64) begin
                    prev_f[b] = last_f[b];
                    last_f[b] = cap[b];
                    nfr[b]++;
                    cnt[b] = 0;
                end
            end
            if (!mdc[b] && mdc_prev[b]) begin
                phy_in[b] = 1'b1;
                if (rdop[b] && cnt[b] == 47)
                    phy_in[b] = !phy_present[b];
                else if (rdop[b] && cnt[b] >= 48 && phy_present[b])
                    phy_in[b] = phy_resp[b][63 - cnt[b]];
            end
            mdc_prev[b] = mdc[b];
        end
        if (cyc > 150000) begin
            fails++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    function automatic logic [63:0] mk(input logic [1:0] op, input logic [4:0] phy,
                                       input logic [4:0] dev, input logic [15:0] pl);
        return {32'hFFFF_FFFF, 2'b00, op, phy, dev, 2'b10, pl};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 3000; i++) begin
            rd(12'h174, v);
            if (!v[0]) break;
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(12'h174, v); check("R1 cmd", v, 0);
        rd(12'h180, v); check("R1 phytab", v, 0);
        rd(12'h00C, v); check("R1 bussel", v, 0);
        check("R1 mdc", mdc, 0);
        check("R1 oe", mdio_oe, 0);
    endtask

    task automatic t_config();
        logic [31:0] v;
        wr(12'h000, 32'h000F_0000);
        wr(12'h184, 32'h0000_00A0);   // port 7  -> phy 5
        wr(12'h18C, 32'h0000_7C00);   // port 20 -> phy 31
        wr(12'h190, 32'h0000_0120);   // port 25 -> phy 9
        wr(12'h194, 32'h0000_0060);   // port 31 -> phy 3
        wr(12'h008, 32'h0000_8000);   // port 7  -> bus 2
        wr(12'h00C, 32'hC000_0100);   // port 20 -> bus 1, port 31 -> bus 3, port 25 -> bus 0
        rd(12'h184, v); check("R2 readback", v, 32'h0000_00A0);
        rd(12'h00C, v); check("R3 readback", v, 32'hC000_0100);
        rd(12'h000, v); check("R4 global", v, 32'h000F_0000);
        phy_present[0] = 1; phy_resp[0] = 16'h0F0F;
        phy_present[1] = 1; phy_resp[1] = 16'h1357;
        phy_present[2] = 1; phy_resp[2] = 16'hBEEF;
        phy_present[3] = 0; phy_resp[3] = 16'h0000;
    endtask

    task automatic t_read();
        logic [31:0] v;
        int n0, n1, n3, n2;
        n0 = nfr[0]; n1 = nfr[1]; n2 = nfr[2]; n3 = nfr[3];
        wr(12'h17C, 32'h001E_1234);
        wr(12'h178, 32'h0007_0000);
        wr(12'h174, 32'h0000_0003);
        rd(12'h174, v); check("R5 busy while running", v[0], 1);
        wait_idle();
        rd(12'h178, v); check("R6 read data", v, 32'h0007_BEEF);
        rd(12'h174, v); check("R5 cmd after good read", v, 32'h0000_0002);
        check("R12 bus2 frame count", nfr[2] - n2, 2);
        check("R12 other buses idle", {32'(nfr[0]-n0), 32'(nfr[1]-n1 + nfr[3]-n3)}, 0);
        check("R8 address frame", prev_f[2], mk(2'b00, 5'd5, 5'd30, 16'h1234));
        check("R8 read frame head", last_f[2][63:18], mk(2'b11, 5'd5, 5'd30, 16'hFFFF) >> 18);
        check("R9 mdc period", gap[2], 2 * HALF);
    endtask

    task automatic t_write();
        logic [31:0] v;
        int n0, n1;
        n0 = nfr[0]; n1 = nfr[1];
        wr(12'h170, (32'd1 << 20) | (32'd1 << 25));
        wr(12'h178, 32'hA5C3_0000);
        wr(12'h17C, 32'h0001_0002);
        wr(12'h174, 32'h0000_0007);
        wait_idle();
        check("R7 lowest port bus", nfr[1] - n1, 2);
        check("R7 higher port untouched", nfr[0] - n0, 0);
        check("R8 write address frame", prev_f[1], mk(2'b00, 5'd31, 5'd1, 16'h0002));
        check("R7 write frame", last_f[1], mk(2'b01, 5'd31, 5'd1, 16'hA5C3));
        rd(12'h174, v); check("R5 cmd after write", v, 32'h0000_0006);
    endtask

    task automatic t_absent();
        logic [31:0] v;
        int n3;
        n3 = nfr[3];
        wr(12'h17C, 32'h0003_0010);
        wr(12'h178, 32'h001F_0000);
        wr(12'h174, 32'h0000_0003);
        wait_idle();
        rd(12'h174, v); check("R10 fail set", v, 32'h0200_0002);
        rd(12'h178, v); check("R10 data ones", v, 32'h001F_FFFF);
        check("R10 frames still sent", nfr[3] - n3, 2);
        // a good read afterwards clears fail
        wr(12'h178, 32'h0019_0000);
        wr(12'h174, 32'h0000_0003);
        wait_idle();
        rd(12'h174, v); check("R5 fail cleared", v, 32'h0000_0002);
        rd(12'h178, v); check("R6 port 25 data", v, 32'h0019_0F0F);
        check("R8 port 25 phy", prev_f[0], mk(2'b00, 5'd9, 5'd3, 16'h0010));
    endtask

    task automatic t_busy_ignore();
        logic [31:0] v;
        int n1, n2;
        n1 = nfr[1]; n2 = nfr[2];
        wr(12'h17C, 32'h0004_0055);
        wr(12'h178, 32'h0007_0000);
        wr(12'h174, 32'h0000_0003);
        repeat (20) @(negedge clk);
        wr(12'h174, 32'h0000_0007);
        rd(12'h174, v); check("R11 bits unchanged while busy", v, 32'h0000_0003);
        wait_idle();
        repeat (300) @(negedge clk);
        check("R11 no second command", nfr[1] - n1, 0);
        check("R11 first command ran", nfr[2] - n2, 2);
        rd(12'h178, v); check("R11 read result kept", v, 32'h0007_BEEF);
    endtask

    task automatic t_no_c45();
        logic [31:0] v;
        int n1, n2;
        n1 = nfr[1]; n2 = nfr[2];
        wr(12'h000, 32'h000B_0000);
        wr(12'h178, 32'h0007_0000);
        wr(12'h174, 32'h0000_0003);
        rd(12'h174, v); check("R4 disabled bus fails at once", v, 32'h0200_0002);
        wr(12'h000, 32'h000F_0000);
        wr(12'h178, 32'h0014_0000);
        wr(12'h174, 32'h0000_0001);
        rd(12'h174, v); check("R4 type bit clear fails", v, 32'h0200_0000);
        repeat (300) @(negedge clk);
        check("R4 no frames", {32'(nfr[1] - n1), 32'(nfr[2] - n2)}, 0);
        check("R4 clocks quiet", mdc, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_config();
        t_read();
        t_write();
        t_absent();
        t_busy_ignore();
        t_no_c45();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule